// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for the fixed-point loads and stores of a 64-bit core, and it decides whether the base register is written back with that address. Each request supplies:

- the base register index and its value;
- a second register value, used by the indexed form;
- a 16-bit displacement field;
- a two-bit addressing-mode select;
- load/store and update flags;
- the target (load) or source (store) register index and the source value.

One cycle after a valid request, the block returns the following:

- the 64-bit effective address;
- a writeback enable for the base register, with its index and data;
- the store data;
- a flag that marks an illegal update encoding.

The displacement is read in one of three ways. The plain form takes all 16 bits as a signed byte offset. The word-scaled form keeps the upper 14 bits and appends two zero bits. The quad-scaled form keeps the upper 12 bits and appends four zero bits. In every form, a base index of zero means a base of zero, not the contents of register 0.

Top module: `agen_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid`, `wb_en` and `bad_form` are 0 and `ea` is 0.
- R2: With `mode`=0 (plain), `ea` = base + the 16-bit `disp` sign-extended to 64 bits.
- R3: With `mode`=1 (word-scaled), `ea` = base + sign-extend({`disp[15:2]`, 2'b00}); `disp[1:0]` has no effect on the address.
- R4: With `mode`=2 (quad-scaled), `ea` = base + sign-extend({`disp[15:4]`, 4'b0000}); `disp[3:0]` has no effect on the address.
- R5: With `mode`=3 (indexed), `ea` = base + `rb_val`, using all 64 bits.
- R6: When `ra_idx` is 0, the base is taken as 0 in every mode, whatever the value of `ra_val`.
- R7: For an update load (`upd`=1, `is_store`=0) with `ra_idx`≠0 and `ra_idx`≠`rt_idx`, the block sets `wb_en`=1, `wb_idx`=`ra_idx` and `wb_data`=`ea`, and `bad_form`=0.
- R8: For an update load with `ra_idx`=0 or `ra_idx`=`rt_idx`, the block sets `bad_form`=1 and `wb_en`=0.
- R9: For an update store, `wb_en`=1 exactly when `ra_idx`≠0, with `wb_data`=`ea` and `bad_form`=0. A store with `ra_idx`=0 makes no writeback.
- R10: For a store, `st_data` is the `src_val` presented with the request, which is the register's value before any update. This holds even when `rt_idx` equals `ra_idx`, so the stored value is never the new address. For a load, `st_data` is 0.
- R11: Address addition wraps modulo 2^64.
- R12: `out_valid` is high exactly one cycle after `in_valid` was high. When `out_valid` is low, `wb_en` and `bad_form` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| mode | input | 2 | 0 plain, 1 word-scaled, 2 quad-scaled, 3 indexed |
| is_store | input | 1 | 1 = store, 0 = load |
| upd | input | 1 | Update form |
| ra_idx | input | 5 | Base register index |
| ra_val | input | 64 | Base register value |
| rb_val | input | 64 | Index register value |
| disp | input | 16 | Displacement field |
| rt_idx | input | 5 | Load target / store source index |
| src_val | input | 64 | Store source register value |
| out_valid | output | 1 | Result valid |
| ea | output | 64 | Effective address |
| wb_en | output | 1 | Base register writeback enable |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 64 | Writeback data |
| st_data | output | 64 | Store data |
| bad_form | output | 1 | Illegal update form |

## Verification
The address path is exercised in each of the four modes with the following patterns:

- displacements that are negative, positive with low bits set, and at the sign boundary (0x8005), which separate sign extension from scaling and from masking of the low bits;
- a zero base index with a nonzero base value, which shows whether register 0 is wrongly read;
- a base near 2^64 with a positive offset, which shows whether the addition wraps.

The update logic is tried with four cases: a legal load, a load whose target matches its base, a load with a zero base, and stores with a zero and a matching base. Together these separate the load rule from the store rule. Idle cycles between requests show that the result lasts one cycle only.

// File: rtl/agen_pkg.sv
package agen_pkg;
    localparam int XLEN     = 64;
    localparam int RIDX_W   = 5;
    localparam int DISP_W   = 16;
    localparam int WS_SHIFT = 2;
    localparam int QS_SHIFT = 4;

    typedef enum logic [1:0] {
        AM_PLAIN = 2'd0,
        AM_WORD  = 2'd1,
        AM_QUAD  = 2'd2,
        AM_INDEX = 2'd3
    } amode_e;

    typedef struct packed {
        logic wb_en;
        logic bad;
    } upd_dec_t;

    function automatic logic [DISP_W-1:0] clear_low(input logic [DISP_W-1:0] f, input int n);
        logic [DISP_W-1:0] m;
        m = '1;
        m = m << n;
        return f & m;
    endfunction
endpackage

// File: rtl/agen_base.sv
module agen_base #(
    parameter int XLEN   = agen_pkg::XLEN,
    parameter int RIDX_W = agen_pkg::RIDX_W
) (
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [XLEN-1:0]   ra_val,
    output logic [XLEN-1:0]   base
);
    always_comb begin
        base = (ra_idx == '0) ? '0 : ra_val;
    end
endmodule

// File: rtl/agen_offset.sv
module agen_offset
    import agen_pkg::*;
#(
    parameter int XLEN   = agen_pkg::XLEN,
    parameter int DISP_W = agen_pkg::DISP_W
) (
    input  amode_e            mode,
    input  logic [DISP_W-1:0] disp,
    input  logic [XLEN-1:0]   rb_val,
    output logic [XLEN-1:0]   offset
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [DISP_W-1:0] field;

    always_comb begin
        unique case (mode)
            AM_WORD: field = clear_low(disp, WS_SHIFT);
            AM_QUAD: field = clear_low(disp, QS_SHIFT);
            default: field = disp;
        endcase
        if (mode == AM_INDEX)
            offset = rb_val;
        else
            offset = {{EXT_W{field[DISP_W-1]}}, field};
    end
endmodule

// File: rtl/agen_upd.sv
module agen_upd
    import agen_pkg::*;
#(
    parameter int RIDX_W = agen_pkg::RIDX_W
) (
    input  logic              upd,
    input  logic              is_store,
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [RIDX_W-1:0] rt_idx,
    output upd_dec_t          dec
);
    logic ra_zero;
    logic ra_hit;

    always_comb begin
        ra_zero   = (ra_idx == '0);
        ra_hit    = (ra_idx == rt_idx);
        dec       = '0;
        if (upd) begin
            if (is_store) begin
                dec.wb_en = !ra_zero;
            end else begin
                dec.bad   = ra_zero || ra_hit;
                dec.wb_en = !(ra_zero || ra_hit);
            end
        end
    end
endmodule

// File: rtl/agen_top.sv
module agen_top
    import agen_pkg::*;
#(
    parameter int XLEN   = agen_pkg::XLEN,
    parameter int RIDX_W = agen_pkg::RIDX_W,
    parameter int DISP_W = agen_pkg::DISP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic              is_store,
    input  logic              upd,
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    input  logic [DISP_W-1:0] disp,
    input  logic [RIDX_W-1:0] rt_idx,
    input  logic [XLEN-1:0]   src_val,
    output logic              out_valid,
    output logic [XLEN-1:0]   ea,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic [XLEN-1:0]   st_data,
    output logic              bad_form
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] sum;
    upd_dec_t        dec;
    amode_e          mode_e;

    assign mode_e = amode_e'(mode);

    agen_base #(.XLEN(XLEN), .RIDX_W(RIDX_W)) base_i (
        .ra_idx (ra_idx),
        .ra_val (ra_val),
        .base   (base)
    );

    agen_offset #(.XLEN(XLEN), .DISP_W(DISP_W)) off_i (
        .mode   (mode_e),
        .disp   (disp),
        .rb_val (rb_val),
        .offset (offset)
    );

    agen_upd #(.RIDX_W(RIDX_W)) upd_i (
        .upd      (upd),
        .is_store (is_store),
        .ra_idx   (ra_idx),
        .rt_idx   (rt_idx),
        .dec      (dec)
    );

    assign sum = base + offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            ea        <= '0;
            wb_en     <= 1'b0;
            wb_idx    <= '0;
            st_data   <= '0;
            bad_form  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wb_en     <= in_valid && dec.wb_en;
            bad_form  <= in_valid && dec.bad;
            if (in_valid) begin
                ea      <= sum;
                wb_idx  <= ra_idx;
                st_data <= is_store ? src_val : '0;
            end
        end
    end

    assign wb_data = ea;
endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
    parameter int XLEN   = agen_pkg::XLEN,
    parameter int RIDX_W = agen_pkg::RIDX_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [XLEN-1:0]   ea,
    input logic              wb_en,
    input logic [RIDX_W-1:0] wb_idx,
    input logic [XLEN-1:0]   wb_data,
    input logic              bad_form
);
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                   // R12
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                 // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !wb_en && !bad_form);                       // R12
    AST_WB_OR_BAD: assert property (@(posedge clk) disable iff (rst)
        !(wb_en && bad_form));                                     // R8
    AST_WB_NONZERO: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> wb_idx != '0);                                   // R7
    AST_WB_IS_EA: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> wb_data == ea);                                  // R9
endmodule

bind agen_top agen_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .ea        (ea),
    .wb_en     (wb_en),
    .wb_idx    (wb_idx),
    .wb_data   (wb_data),
    .bad_form  (bad_form)
);

// File: tb/agen_top_tb_top.sv
module agen_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  mode;
    logic        is_store;
    logic        upd;
    logic [4:0]  ra_idx;
    logic [63:0] ra_val;
    logic [63:0] rb_val;
    logic [15:0] disp;
    logic [4:0]  rt_idx;
    logic [63:0] src_val;
    logic        out_valid;
    logic [63:0] ea;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;
    logic [63:0] st_data;
    logic        bad_form;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    agen_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .is_store(is_store),
        .upd(upd), .ra_idx(ra_idx), .ra_val(ra_val), .rb_val(rb_val), .disp(disp),
        .rt_idx(rt_idx), .src_val(src_val), .out_valid(out_valid), .ea(ea),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .st_data(st_data),
        .bad_form(bad_form)
    );

    localparam int NV = 10;
    localparam logic [1:0]  V_MODE [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd0, 2'd0, 2'd0, 2'd1, 2'd0};
    localparam logic        V_ST   [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic        V_UPD  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [4:0]  V_RA   [NV] = '{5'd1, 5'd4, 5'd5, 5'd6, 5'd0, 5'd3, 5'd3, 5'd0, 5'd7, 5'd0};
    localparam logic [4:0]  V_RT   [NV] = '{5'd2, 5'd9, 5'd8, 5'd2, 5'd2, 5'd4, 5'd3, 5'd4, 5'd7, 5'd5};
    localparam logic [63:0] V_BASE [NV] = '{64'h1000, 64'h2000, 64'h0, 64'h10, 64'hDEAD,
                                            64'h5000, 64'h5000, 64'h7777, 64'h9000, 64'h4444};
    localparam logic [63:0] V_IDX  [NV] = '{64'h33, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h40,
                                            64'h0, 64'h0, 64'h0, 64'h0, 64'h0};
    localparam logic [15:0] V_DISP [NV] = '{16'hFFF0, 16'h0013, 16'h8005, 16'h0, 16'h0,
                                            16'h0008, 16'h0008, 16'h0010, 16'hFFFF, 16'h0020};
    localparam logic [63:0] V_SRC  [NV] = '{64'h0, 64'hABCD, 64'h0, 64'h0, 64'h0,
                                            64'h0, 64'h0, 64'h0, 64'h9000, 64'h1234};

    function automatic logic [63:0] model_ea(input logic [1:0] m, input logic [4:0] ra,
                                             input logic [63:0] b, input logic [63:0] x,
                                             input logic [15:0] d);
        logic [63:0] bb;
        logic [63:0] off;
        bb = (ra == 5'd0) ? 64'd0 : b;
        case (m)
            2'd0:    off = {{48{d[15]}}, d};
            2'd1:    off = {{48{d[15]}}, d[15:2], 2'b00};
            2'd2:    off = {{48{d[15]}}, d[15:4], 4'b0000};
            default: off = x;
        endcase
        return bb + off;
    endfunction

    task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic st, input logic u,
                         input logic [4:0] ra, input logic [4:0] rt,
                         input logic [63:0] b, input logic [63:0] x,
                         input logic [15:0] d, input logic [63:0] s);
        @(negedge clk);
        in_valid = 1'b1; mode = m; is_store = st; upd = u;
        ra_idx = ra; rt_idx = rt; ra_val = b; rb_val = x; disp = d; src_val = s;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; mode = 2'd0; is_store = 1'b0; upd = 1'b0;
        ra_idx = '0; rt_idx = '0; ra_val = '0; rb_val = '0; disp = '0; src_val = '0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        chk64("R1 out_valid", {63'd0, out_valid}, 64'd0);
        chk64("R1 wb_en", {63'd0, wb_en}, 64'd0);
        chk64("R1 bad_form", {63'd0, bad_form}, 64'd0);
        chk64("R1 ea", ea, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk64("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);

        // Vector walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            logic wb_x;
            logic bad_x;
            drive(V_MODE[i], V_ST[i], V_UPD[i], V_RA[i], V_RT[i], V_BASE[i], V_IDX[i], V_DISP[i], V_SRC[i]);
            wb_x  = V_UPD[i] && V_RA[i] != 5'd0 && (V_ST[i] || V_RA[i] != V_RT[i]);
            bad_x = V_UPD[i] && !V_ST[i] && (V_RA[i] == 5'd0 || V_RA[i] == V_RT[i]);
            chk64("R12 out_valid", {63'd0, out_valid}, 64'd1);
            chk64("R2-mode ea", ea, model_ea(V_MODE[i], V_RA[i], V_BASE[i], V_IDX[i], V_DISP[i]));
            chk64("R7 wb_en", {63'd0, wb_en}, {63'd0, wb_x});
            chk64("R8 bad_form", {63'd0, bad_form}, {63'd0, bad_x});
            if (wb_x) begin
                chk64("R9 wb_idx", {59'd0, wb_idx}, {59'd0, V_RA[i]});
                chk64("R9 wb_data", wb_data, ea);
            end
            chk64("R10 st_data", st_data, V_ST[i] ? V_SRC[i] : 64'd0);
        end

        // R3: word-scaled drops low two bits
        drive(2'd1, 1'b0, 1'b0, 5'd2, 5'd1, 64'h100, 64'h0, 16'h0007, 64'h0);
        chk64("R3 ea", ea, 64'h104);
        // R4: quad-scaled, all-ones field gives -16
        drive(2'd2, 1'b0, 1'b0, 5'd2, 5'd1, 64'h100, 64'h0, 16'hFFFF, 64'h0);
        chk64("R4 ea", ea, 64'hF0);
        // R2: plain negative displacement
        drive(2'd0, 1'b0, 1'b0, 5'd2, 5'd1, 64'h100, 64'h0, 16'h8000, 64'h0);
        chk64("R2 ea", ea, 64'hFFFF_FFFF_FFFF_8100);
        // R11: wrap around
        drive(2'd0, 1'b0, 1'b0, 5'd3, 5'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0002, 64'h0);
        chk64("R11 ea", ea, 64'h1);
        // R6: zero base index ignores value in indexed mode
        drive(2'd3, 1'b0, 1'b0, 5'd0, 5'd1, 64'hFFFF_0000_0000_0000, 64'h88, 16'h0, 64'h0);
        chk64("R6 ea", ea, 64'h88);
        // R10: store with source equal to base keeps old value, not address
        drive(2'd0, 1'b1, 1'b1, 5'd9, 5'd9, 64'h3000, 64'h0, 16'h0010, 64'h3000);
        chk64("R10 st_data old", st_data, 64'h3000);
        chk64("R9 wb_data new", wb_data, 64'h3010);
        // R12: next idle cycle drops valid and update
        @(negedge clk);
        chk64("R12 idle out_valid", {63'd0, out_valid}, 64'd0);
        chk64("R12 idle wb_en", {63'd0, wb_en}, 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule